// File: doc/BRIEF.md
# Event-Driven PWM Action Generator

A single-channel PWM generator. A counter cycles against a programmable period value, and four comparison points are watched: the counter reaching zero, the counter reaching the period value, and the counter matching either of two compare values. Each compare match is split by the direction the counter is moving, which gives six event kinds. Every event kind has its own 2-bit action code. The code either leaves the output alone, inverts it, forces it low or forces it high.

The counter has two modes. In down mode it counts down and reloads from the period value after reaching zero. In up/down mode it climbs from zero to the period value, falls back to zero, and repeats. When several events land in the same cycle, a fixed priority picks one action. Software configures the block through a simple write-only register port and then sets the enable bit.

Top module: `pwm_event_gen`

## Requirements
- R1: After reset the output `pwm_out` is low and `count_out` is 0.
- R2: While the enable bit (bit 0 of the control register at address 0) is clear, the counter stays at 0 and `pwm_out` stays low, whatever the other registers hold.
- R3: With the mode bit (bit 1 of the control register) clear, the counter steps down by one each cycle. After reaching 0 it reloads from the period register (address 1).
- R4: With the mode bit set, the counter starts from 0 and steps up to the period value, then down to 0, and repeats. A period of 0 keeps it at 0.
- R5: The action codes are 00 = keep, 01 = invert, 10 = drive low and 11 = drive high. Their fields in the action register (address 4) are: bits 1:0 zero, 3:2 period reached, 5:4 compare A while rising, 7:6 compare A while falling, 9:8 compare B while rising, 11:10 compare B while falling. Compare A is at address 2 and compare B at address 3.
- R6: In down mode the rising-compare fields have no effect, and a compare match uses the falling field.
- R7: When a zero or period event falls in the same cycle as a compare match, only the zero or period action is applied. Zero outranks period.
- R8: When compare A and compare B match in the same cycle, only the compare A action is applied.
- R9: `pwm_out` changes on the clock edge that follows the cycle in which the event's count value is present on `count_out`.
- R10: Bits above bit 11 of the action register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1 period, 2 compare A, 3 compare B, 4 action |
| wr_data | input | CNT_W (16) | Write data |
| pwm_out | output | 1 | PWM output |
| count_out | output | CNT_W (16) | Current counter value |

## Verification
The bench builds the block with its default 16-bit counter. It uses short period values, up to about twenty, so that many complete periods and direction reversals fit in each run. Because the periods are small, compare values of 0, equal to the period, equal to each other, or just beyond the period come up often. Every coincidence in the priority rules is therefore reached, both in directed cases and among the seeded random configurations.

// File: rtl/pwm_event_gen.sv
module pwm_event_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count_out
);
  localparam int ACT_W = 12;

  logic             en, mode, rising;
  logic [CNT_W-1:0] period, cmp_a, cmp_b, cnt;
  logic [ACT_W-1:0] act;
  logic [1:0]       sel;
  logic             ev_zero, ev_per, ev_a_up, ev_a_dn, ev_b_up, ev_b_dn, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mode <= 1'b0;
      period <= '0; cmp_a <= '0; cmp_b <= '0; act <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin en <= wr_data[0]; mode <= wr_data[1]; end
        3'd1: period <= wr_data;
        3'd2: cmp_a <= wr_data;
        3'd3: cmp_b <= wr_data;
        3'd4: act <= wr_data[ACT_W-1:0];
        default: ;
      endcase
    end
  end

  assign ev_zero = en && (cnt == '0);
  assign ev_per  = en && (cnt == period);
  assign ev_a_up = en && mode && rising && (cnt == cmp_a);
  assign ev_a_dn = en && !rising && (cnt == cmp_a);
  assign ev_b_up = en && mode && rising && (cnt == cmp_b);
  assign ev_b_dn = en && !rising && (cnt == cmp_b);
  assign hit = ev_zero | ev_per | ev_a_up | ev_a_dn | ev_b_up | ev_b_dn;

  always_comb begin
    if      (ev_zero) sel = act[1:0];
    else if (ev_per)  sel = act[3:2];
    else if (ev_a_up) sel = act[5:4];
    else if (ev_a_dn) sel = act[7:6];
    else if (ev_b_up) sel = act[9:8];
    else if (ev_b_dn) sel = act[11:10];
    else              sel = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; rising <= 1'b0; pwm_out <= 1'b0;
    end else if (!en) begin
      cnt <= '0; rising <= 1'b0; pwm_out <= 1'b0;
    end else begin
      case (sel)
        2'b01: pwm_out <= ~pwm_out;
        2'b10: pwm_out <= 1'b0;
        2'b11: pwm_out <= 1'b1;
        default: ;
      endcase
      if (!mode) begin
        rising <= 1'b0;
        cnt <= (cnt == '0) ? period : cnt - 1'b1;
      end else if (period == '0) begin
        rising <= 1'b0;
        cnt <= '0;
      end else if (cnt >= period) begin
        rising <= 1'b0;
        cnt <= cnt - 1'b1;
      end else if (cnt == '0) begin
        rising <= 1'b1;
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= rising ? cnt + 1'b1 : cnt - 1'b1;
      end
    end
  end

  assign count_out = cnt;
endmodule

module pwm_event_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic [1:0]       act_zero,
  input logic             ev_zero,
  input logic             hit,
  input logic             pwm
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0) && !pwm);

  a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && cnt != '0) |=> cnt == $past(cnt) - 16'd1);

  a_r3_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && cnt == '0) |=> cnt == $past(period));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && cnt != '0 && cnt < period) |=>
      (cnt == $past(cnt) + 16'd1) || (cnt == $past(cnt) - 16'd1));

  a_r7_zero_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_zero && act_zero == 2'b10) |=> !pwm);

  a_r9_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit) |=> $stable(pwm));
endmodule

bind pwm_event_gen pwm_event_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cnt(cnt),
  .period(period), .act_zero(act[1:0]), .ev_zero(ev_zero), .hit(hit),
  .pwm(pwm_out)
);

// File: tb/pwm_event_gen_bench.sv
module pwm_event_gen_bench;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pwm_out;
  logic [W-1:0] count_out;

  int total = 0, bad = 0;
  string tag = "R1";

  // reference state
  logic m_en = 0, m_mode = 0, m_up = 0, m_pwm = 0;
  logic [W-1:0] m_per = 0, m_a = 0, m_b = 0, m_cnt = 0;
  logic [11:0] m_act = 0;
  logic pend = 0;
  logic [2:0] p_addr = 0;
  logic [W-1:0] p_data = 0;

  pwm_event_gen u_pwm_event_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .count_out(count_out));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic apply(input logic [1:0] code, input logic cur);
    case (code)
      2'b01: return ~cur;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic logic [1:0] pick();
    if (m_cnt == 0) return m_act[1:0];
    if (m_cnt == m_per) return m_act[3:2];
    if (m_cnt == m_a && m_mode && m_up) return m_act[5:4];
    if (m_cnt == m_a && !m_up) return m_act[7:6];
    if (m_cnt == m_b && m_mode && m_up) return m_act[9:8];
    if (m_cnt == m_b && !m_up) return m_act[11:10];
    return 2'b00;
  endfunction

  task automatic model_step();
    if (!m_en) begin
      m_cnt = 0; m_up = 0; m_pwm = 0;
    end else begin
      m_pwm = apply(pick(), m_pwm);
      if (!m_mode) begin
        m_up = 0;
        m_cnt = (m_cnt == 0) ? m_per : m_cnt - 1'b1;
      end else if (m_per == 0) begin
        m_up = 0; m_cnt = 0;
      end else if (m_cnt >= m_per) begin
        m_up = 0; m_cnt = m_cnt - 1'b1;
      end else if (m_cnt == 0) begin
        m_up = 1; m_cnt = 1;
      end else begin
        m_cnt = m_up ? m_cnt + 1'b1 : m_cnt - 1'b1;
      end
    end
  endtask

  task automatic check();
    total++;
    if (pwm_out !== m_pwm || count_out !== m_cnt) begin
      bad++;
      $display("FAIL %s: pwm=%0b cnt=%0d expected pwm=%0b cnt=%0d",
               tag, pwm_out, count_out, m_pwm, m_cnt);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    if (pend) begin
      case (p_addr)
        3'd0: begin m_en = p_data[0]; m_mode = p_data[1]; end
        3'd1: m_per = p_data;
        3'd2: m_a = p_data;
        3'd3: m_b = p_data;
        3'd4: m_act = p_data[11:0];
        default: ;
      endcase
      pend = 0;
    end
    @(negedge clk);
    check();
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    pend = 1; p_addr = a; p_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic scenario(input string t, input logic md, input int per,
                          input int ca, input int cb, input logic [W-1:0] ac,
                          input int n);
    tag = t;
    wr(0, 0);
    wr(1, W'(per)); wr(2, W'(ca)); wr(3, W'(cb)); wr(4, ac);
    wr(0, {14'd0, md, 1'b1});
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    #(CLK_P*2 + 1);
    @(negedge clk);
    tag = "R1"; check();
    rst_n = 1;
    tick();
    // R2: configured but disabled
    tag = "R2";
    wr(1, 7); wr(2, 3); wr(4, 16'h0FFF);
    for (int i = 0; i < 6; i++) tick();
    // R3 and R5: down mode, zero high, A-down low, B-down invert
    scenario("R3", 0, 9, 6, 3, 16'b0100_1000_0011, 40);
    // R6: rising fields set to invert must not act in down mode
    scenario("R6", 0, 10, 4, 7, 16'b1001_1001_0011, 40);
    // R4: up/down, A-up high, A-down low
    scenario("R4", 1, 8, 5, 2, 16'b0000_1011_0000, 50);
    scenario("R4", 1, 0, 0, 0, 16'b0000_0000_0001, 10);
    // R7: compares at 0 and at period, compare actions would invert
    scenario("R7", 1, 6, 0, 6, 16'b0101_0101_1011, 40);
    scenario("R7", 0, 6, 6, 0, 16'b0101_0101_0111, 40);
    // R8: A and B coincide, A drives high, B drives low
    scenario("R8", 1, 9, 4, 4, 16'b1010_1111_0000, 40);
    scenario("R8", 0, 9, 4, 4, 16'b1000_1100_0000, 40);
    // R9: single invert on compare A, latency of one edge
    scenario("R9", 0, 5, 2, 9, 16'b0000_0100_0000, 20);
    // R10: upper action bits set, lower fields keep
    scenario("R10", 1, 7, 3, 5, 16'hF000, 30);
    // R5: every event inverts
    scenario("R5", 1, 11, 3, 8, 16'h0555, 50);
    for (int k = 0; k < 40; k++) begin
      int per = int'($urandom % 21);
      scenario("R5", 1'($urandom), per, int'($urandom % (per + 2)),
               int'($urandom % (per + 2)), W'($urandom), 60);
    end
    tag = "R2";
    wr(0, 0);
    for (int i = 0; i < 4; i++) tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule